// File: doc/BRIEF.md
# Two-Address Serial Command Port for a Display and Key Controller

This block is the serial slave front end of a two-digit display and key-matrix controller. A host drives a shift clock, a chip enable and a data line, and watches a single open-drain reply line. With chip enable low, the host shifts in an 8-bit address, least significant bit first. When chip enable rises, that address selects one of two transfers. The write address opens a 64-bit payload that carries one half of the segment image, the sleep and dimmer controls, and a 2-bit tag that says which half it is. The read address turns the reply line into a data output that shifts out the key matrix state and a sleep acknowledge bit.

The serial pins are oversampled with the system clock. A write payload reaches the parallel latches only when chip enable falls after exactly 64 bits, and only if the tag is valid. Any other frame leaves every latch as it was. Outside a transfer, the reply line doubles as the key service request: it is pulled low while the scanner holds its request. The blanking input silences the reply line and blocks key reads, but it clears no latch, so the host can load a full image while the display is dark.

Top module: `cmd_serial_if`

## Requirements
- R1: The address byte 8Eh (bit string 0,1,1,1,0,0,0,1 on the wire) selects a write. A write of exactly 64 payload bits with tag bits 63:62 equal to 01 loads payload bits 40:0 into the digit-1 segment latch. The first payload bit on the wire is bit 0 and drives segment 1.
- R2: A valid write whose tag is 10 loads payload bits 40:0 into the digit-2 segment latch. The digit-1 latch is left unchanged.
- R3: Every valid write also loads the sleep field from payload bits 42:41 and the 10-bit dimmer from bits 52:43, with bit 43 as the dimmer LSB.
- R4: Latches change only on the chip-enable falling edge that ends a valid write. A frame of 63 or 65 bits, or one with tag 00 or 11, changes nothing.
- R5: A transfer under any address other than 8Eh or 8Fh changes no latch, and the reply line stays released while chip enable is high.
- R6: The address 8Fh selects a read. Once chip enable rises, the reply line shows key bit 1. After each shift-clock falling edge it moves to the next bit: key bits 1 to 30, then the sleep acknowledge (1 when either sleep bit is set, else 0), then released high.
- R7: With chip enable low and no read in progress, the reply line is low exactly when key_req_i is high. With chip enable high outside a read, the line is released.
- R8: read_done_o is a one-cycle pulse, issued when chip enable falls after a read of at least 31 shift-clock falling edges. A shorter read gives no pulse.
- R9: While blank_ni is low, the reply line is released, reads give no read_done_o pulse, and writes still load the latches.
- R10: rst_ni low clears all latches to zero and releases the reply line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| blank_ni | input | 1 | Active-low blanking; does not clear the latches |
| sclk_i | input | 1 | Serial shift clock from the host |
| ce_i | input | 1 | Chip enable: address phase when low, payload phase when high |
| sdi_i | input | 1 | Serial data in, LSB first |
| sdo_o | output | 1 | Open-drain reply line level (1 = released) |
| key_data_i | input | 30 | Key matrix state, bit 0 = key 1 |
| key_req_i | input | 1 | Key service request from the scanner |
| seg_g1_o | output | 41 | Digit-1 segment latch, bit 0 = segment 1 |
| seg_g2_o | output | 41 | Digit-2 segment latch |
| sleep_o | output | 2 | Sleep control bits |
| dimmer_o | output | 10 | Dimmer value |
| read_done_o | output | 1 | Pulse when a key read completes |

## Verification
On every cycle, the assertions check the following. The reply line is released during blanking, and it is released whenever neither a key request nor a read is active. The segment latches hold steady in every cycle that is not a write commit, and read_done_o never lasts two cycles. Only the bench scenarios can show which addresses and frame lengths count as valid, where each payload field lands, and the bit order of the read stream including the sleep acknowledge. They also show that blanked writes are kept and blanked reads are suppressed.

// File: rtl/cmd_serial_pkg.sv
package cmd_serial_pkg;
  localparam int ADDR_W = 8;

  typedef enum logic [1:0] {
    M_ADDR  = 2'd0,
    M_WRITE = 2'd1,
    M_READ  = 2'd2,
    M_SKIP  = 2'd3
  } mode_e;

  localparam logic [1:0] TAG_G1 = 2'b01;
  localparam logic [1:0] TAG_G2 = 2'b10;
endpackage

// File: rtl/cmd_sync.sv
module cmd_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [STAGES-1:0][W-1:0] st_q;
  logic [W-1:0]             prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= {st_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= st_q[STAGES-1];
  end

  assign q_o      = st_q[STAGES-1];
  assign q_prev_o = prev_q;
endmodule

// File: rtl/cmd_frame.sv
module cmd_frame
  import cmd_serial_pkg::*;
#(
  parameter int              SEG_W   = 41,
  parameter int              DIM_W   = 10,
  parameter int              FRAME_W = 64,
  parameter int              RD_W    = 31,
  parameter logic [ADDR_W-1:0] WR_ADDR = 8'h8E,
  parameter logic [ADDR_W-1:0] RD_ADDR = 8'h8F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_s_i,
  input  logic             sdi_s_i,
  input  logic             sclk_rise_i,
  input  logic             sclk_fall_i,
  input  logic             ce_rise_i,
  input  logic             ce_fall_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [1:0]       slp_o,
  output logic [DIM_W-1:0] dim_o,
  output logic [1:0]       tag_o,
  output logic             wr_commit_o,
  output logic             rd_load_o,
  output logic             rd_shift_o,
  output logic             rd_active_o,
  output logic             rd_done_o
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int SLP_LSB = SEG_W;
  localparam int DIM_LSB = SEG_W + 2;
  localparam int TAG_LSB = FRAME_W - 2;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_RD   = CNT_W'(RD_W);

  mode_e               mode_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [FRAME_W-1:0]  sh_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                cnt_step;

  assign cnt_step = ((mode_q == M_WRITE) && sclk_rise_i) ||
                    ((mode_q == M_READ)  && sclk_fall_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_ADDR;
      addr_q <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else if (ce_fall_i) begin
      mode_q <= M_ADDR;
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (ce_rise_i && mode_q == M_ADDR) begin
      cnt_q <= '0;
      if (addr_q == WR_ADDR)      mode_q <= M_WRITE;
      else if (addr_q == RD_ADDR) mode_q <= M_READ;
      else                        mode_q <= M_SKIP;
    end else begin
      if (mode_q == M_ADDR && !ce_s_i && sclk_rise_i)
        addr_q <= {sdi_s_i, addr_q[ADDR_W-1:1]};
      if (mode_q == M_WRITE && sclk_rise_i)
        sh_q <= {sdi_s_i, sh_q[FRAME_W-1:1]};
      if (cnt_step && cnt_q != CNT_SAT)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign seg_o       = sh_q[SEG_W-1:0];
  assign slp_o       = sh_q[SLP_LSB +: 2];
  assign dim_o       = sh_q[DIM_LSB +: DIM_W];
  assign tag_o       = sh_q[TAG_LSB +: 2];
  assign wr_commit_o = ce_fall_i && (mode_q == M_WRITE) && (cnt_q == CNT_FULL);
  assign rd_load_o   = ce_rise_i && (mode_q == M_ADDR) && (addr_q == RD_ADDR);
  assign rd_active_o = (mode_q == M_READ);
  assign rd_shift_o  = rd_active_o && sclk_fall_i;
  assign rd_done_o   = ce_fall_i && rd_active_o && (cnt_q >= CNT_RD);
endmodule

// File: rtl/cmd_latch.sv
module cmd_latch
  import cmd_serial_pkg::*;
#(
  parameter int SEG_W = 41,
  parameter int DIM_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [1:0]       slp_i,
  input  logic [DIM_W-1:0] dim_i,
  input  logic [1:0]       tag_i,
  output logic [SEG_W-1:0] seg_g1_o,
  output logic [SEG_W-1:0] seg_g2_o,
  output logic [1:0]       sleep_o,
  output logic [DIM_W-1:0] dimmer_o
);
  logic tag_ok;
  assign tag_ok = (tag_i == TAG_G1) || (tag_i == TAG_G2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_g1_o <= '0;
      seg_g2_o <= '0;
      sleep_o  <= '0;
      dimmer_o <= '0;
    end else if (commit_i && tag_ok) begin
      if (tag_i == TAG_G1) seg_g1_o <= seg_i;
      else                 seg_g2_o <= seg_i;
      sleep_o  <= slp_i;
      dimmer_o <= dim_i;
    end
  end
endmodule

// File: rtl/cmd_readout.sv
module cmd_readout #(
  parameter int KEY_W = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             blank_ni,
  input  logic             ce_s_i,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             active_i,
  input  logic [KEY_W-1:0] key_data_i,
  input  logic             sleep_ack_i,
  input  logic             key_req_i,
  output logic             sdo_o
);
  localparam int RD_W = KEY_W + 1;

  logic [RD_W-1:0] sh_q;
  logic            sdo_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '1;
    else if (load_i)  sh_q <= {sleep_ack_i, key_data_i};
    else if (shift_i) sh_q <= {1'b1, sh_q[RD_W-1:1]};
  end

  always_comb begin
    if (!blank_ni)     sdo_d = 1'b1;
    else if (active_i) sdo_d = sh_q[0];
    else if (ce_s_i)   sdo_d = 1'b1;
    else               sdo_d = !key_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdo_o <= 1'b1;
    else         sdo_o <= sdo_d;
  end
endmodule

// File: rtl/cmd_serial_if.sv
module cmd_serial_if
  import cmd_serial_pkg::*;
#(
  parameter int              SEG_W       = 41,
  parameter int              KEY_W       = 30,
  parameter int              DIM_W       = 10,
  parameter int              FRAME_W     = 64,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] WR_ADDR   = 8'h8E,
  parameter logic [ADDR_W-1:0] RD_ADDR   = 8'h8F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             blank_ni,
  input  logic             sclk_i,
  input  logic             ce_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  input  logic [KEY_W-1:0] key_data_i,
  input  logic             key_req_i,
  output logic [SEG_W-1:0] seg_g1_o,
  output logic [SEG_W-1:0] seg_g2_o,
  output logic [1:0]       sleep_o,
  output logic [DIM_W-1:0] dimmer_o,
  output logic             read_done_o
);
  localparam int RD_W = KEY_W + 1;

  logic [2:0] pins_s, pins_p;
  logic sclk_s, ce_s, sdi_s;
  logic sclk_rise, sclk_fall, ce_rise, ce_fall;
  logic [SEG_W-1:0] f_seg;
  logic [1:0]       f_slp, f_tag;
  logic [DIM_W-1:0] f_dim;
  logic wr_commit, rd_load, rd_shift, rd_active, rd_done;

  cmd_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      ({sdi_i, ce_i, sclk_i}),
    .q_o      (pins_s),
    .q_prev_o (pins_p)
  );

  assign sclk_s    = pins_s[0];
  assign ce_s      = pins_s[1];
  assign sdi_s     = pins_s[2];
  assign sclk_rise = sclk_s & ~pins_p[0];
  assign sclk_fall = ~sclk_s & pins_p[0];
  assign ce_rise   = ce_s & ~pins_p[1];
  assign ce_fall   = ~ce_s & pins_p[1];

  cmd_frame #(
    .SEG_W(SEG_W), .DIM_W(DIM_W), .FRAME_W(FRAME_W), .RD_W(RD_W),
    .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_s_i      (ce_s),
    .sdi_s_i     (sdi_s),
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .ce_rise_i   (ce_rise),
    .ce_fall_i   (ce_fall),
    .seg_o       (f_seg),
    .slp_o       (f_slp),
    .dim_o       (f_dim),
    .tag_o       (f_tag),
    .wr_commit_o (wr_commit),
    .rd_load_o   (rd_load),
    .rd_shift_o  (rd_shift),
    .rd_active_o (rd_active),
    .rd_done_o   (rd_done)
  );

  cmd_latch #(.SEG_W(SEG_W), .DIM_W(DIM_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (wr_commit),
    .seg_i    (f_seg),
    .slp_i    (f_slp),
    .dim_i    (f_dim),
    .tag_i    (f_tag),
    .seg_g1_o (seg_g1_o),
    .seg_g2_o (seg_g2_o),
    .sleep_o  (sleep_o),
    .dimmer_o (dimmer_o)
  );

  cmd_readout #(.KEY_W(KEY_W)) u_readout (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .blank_ni    (blank_ni),
    .ce_s_i      (ce_s),
    .load_i      (rd_load),
    .shift_i     (rd_shift),
    .active_i    (rd_active),
    .key_data_i  (key_data_i),
    .sleep_ack_i (|sleep_o),
    .key_req_i   (key_req_i),
    .sdo_o       (sdo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) read_done_o <= 1'b0;
    else         read_done_o <= rd_done & blank_ni;
  end
endmodule

// File: rtl/cmd_serial_if_chk.sv
module cmd_serial_if_chk #(
  parameter int SEG_W = 41
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             blank_ni,
  input logic             key_req_i,
  input logic             sdo_o,
  input logic             read_done_o,
  input logic [SEG_W-1:0] seg_g1_o,
  input logic [SEG_W-1:0] seg_g2_o,
  input logic             wr_commit,
  input logic             rd_active
);
  // R9
  blank_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |=> sdo_o);

  // R7
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_req_i && !rd_active) |=> sdo_o);

  // R4
  g1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_commit |=> $stable(seg_g1_o));

  // R4
  g2_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_commit |=> $stable(seg_g2_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_done_o |=> !read_done_o);
endmodule

bind cmd_serial_if cmd_serial_if_chk #(.SEG_W(SEG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .blank_ni    (blank_ni),
  .key_req_i   (key_req_i),
  .sdo_o       (sdo_o),
  .read_done_o (read_done_o),
  .seg_g1_o    (seg_g1_o),
  .seg_g2_o    (seg_g2_o),
  .wr_commit   (wr_commit),
  .rd_active   (rd_active)
);

// File: tb/tb_cmd_serial_if.sv
module tb_cmd_serial_if;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic blank_ni = 1'b1;
  logic sclk = 1'b0, ce = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [29:0] key_data = '0;
  logic key_req = 1'b0;
  logic [40:0] seg_g1, seg_g2;
  logic [1:0] sleep;
  logic [9:0] dimmer;
  logic read_done;

  int n_chk = 0, n_err = 0, n_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (read_done) n_done++;

  cmd_serial_if dut (
    .clk_i(clk), .rst_ni(rst_ni), .blank_ni(blank_ni),
    .sclk_i(sclk), .ce_i(ce), .sdi_i(sdi), .sdo_o(sdo),
    .key_data_i(key_data), .key_req_i(key_req),
    .seg_g1_o(seg_g1), .seg_g2_o(seg_g2), .sleep_o(sleep),
    .dimmer_o(dimmer), .read_done_o(read_done)
  );

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(logic [40:0] seg, logic [1:0] slp,
                                     logic [9:0] dim, logic [1:0] tag);
    logic [63:0] p = '0;
    p[40:0] = seg; p[42:41] = slp; p[52:43] = dim; p[63:62] = tag;
    return p;
  endfunction

  task automatic pulse_bit(logic b);
    sdi = b; wait_clk(HALF);
    sclk = 1'b1; wait_clk(HALF);
    sclk = 1'b0; wait_clk(HALF);
  endtask

  task automatic send_addr(logic [7:0] a);
    ce = 1'b0;
    for (int i = 0; i < 8; i++) pulse_bit(a[i]);
    ce = 1'b1; wait_clk(HALF);
  endtask

  task automatic write_frame(logic [7:0] a, logic [63:0] p, int nbits);
    send_addr(a);
    for (int i = 0; i < nbits; i++) pulse_bit(i < 64 ? p[i] : 1'b0);
    ce = 1'b0; wait_clk(HALF);
  endtask

  // reads nclk bits; checks stream against exp when nclk is full length
  task automatic read_frame(string req, logic [31:0] exp, int nclk, bit do_chk);
    logic [31:0] got = '0;
    send_addr(8'h8F);
    got[0] = sdo;
    for (int i = 0; i < nclk; i++) begin
      sclk = 1'b1; wait_clk(HALF);
      sclk = 1'b0; wait_clk(HALF);
      if (i < 31) got[i+1] = sdo;
    end
    ce = 1'b0; wait_clk(HALF);
    if (do_chk) chk(req, 64'(got), 64'(exp));
  endtask

  task automatic t_reset;
    chk("R10 seg_g1 reset", 64'(seg_g1), 64'h0);
    chk("R10 seg_g2 reset", 64'(seg_g2), 64'h0);
    chk("R10 dimmer/sleep reset", 64'({sleep, dimmer}), 64'h0);
    chk("R10 sdo released", 64'(sdo), 64'h1);
  endtask

  task automatic t_idle_req;
    key_req = 1'b1; wait_clk(4);
    chk("R7 idle request drives low", 64'(sdo), 64'h0);
    ce = 1'b1; wait_clk(HALF);
    chk("R7 ce high releases", 64'(sdo), 64'h1);
    ce = 1'b0; wait_clk(HALF);
    key_req = 1'b0; wait_clk(4);
    chk("R7 no request released", 64'(sdo), 64'h1);
  endtask

  task automatic t_write_halves;
    write_frame(8'h8E, mk(41'h1_2345_6789A, 2'b00, 10'h155, 2'b01), 64);
    chk("R1 digit1 loaded", 64'(seg_g1), 64'h1_2345_6789A);
    chk("R1 digit2 untouched", 64'(seg_g2), 64'h0);
    chk("R3 dimmer from write", 64'(dimmer), 64'h155);
    write_frame(8'h8E, mk(41'h0_ABCD_EF01, 2'b10, 10'h2A5, 2'b10), 64);
    chk("R2 digit2 loaded", 64'(seg_g2), 64'h0_ABCD_EF01);
    chk("R2 digit1 kept", 64'(seg_g1), 64'h1_2345_6789A);
    chk("R3 sleep bits", 64'(sleep), 64'h2);
    chk("R3 dimmer second", 64'(dimmer), 64'h2A5);
  endtask

  task automatic t_discard;
    logic [63:0] p = mk(41'h0_5555_5555, 2'b01, 10'h0F0, 2'b01);
    write_frame(8'h8E, p, 63);
    chk("R4 short frame dropped", 64'(seg_g1), 64'h1_2345_6789A);
    write_frame(8'h8E, p, 65);
    chk("R4 long frame dropped", 64'(seg_g1), 64'h1_2345_6789A);
    write_frame(8'h8E, mk(41'h0_5555_5555, 2'b01, 10'h0F0, 2'b11), 64);
    chk("R4 tag 11 dropped", 64'({seg_g2, seg_g1}), 64'({41'h0_ABCD_EF01, 41'h1_2345_6789A}));
    write_frame(8'h8E, mk(41'h0_5555_5555, 2'b01, 10'h0F0, 2'b00), 64);
    chk("R4 tag 00 dropped", 64'(dimmer), 64'h2A5);
    key_req = 1'b1;
    send_addr(8'h8D);
    for (int i = 0; i < 64; i++) pulse_bit(p[i]);
    chk("R5 sdo released in foreign frame", 64'(sdo), 64'h1);
    ce = 1'b0; wait_clk(HALF);
    key_req = 1'b0;
    chk("R5 foreign address dropped", 64'(seg_g1), 64'h1_2345_6789A);
  endtask

  task automatic t_read;
    int d0;
    key_data = 30'h2ABC_D123; key_req = 1'b1;
    d0 = n_done;
    read_frame("R6 key stream with sleep ack 1", {1'b1, 1'b1, 30'h2ABC_D123}, 31, 1);
    wait_clk(2);
    chk("R8 done pulse after full read", 64'(n_done - d0), 64'h1);
    key_req = 1'b0;
    d0 = n_done;
    read_frame("R8 short read", 32'h0, 10, 0);
    wait_clk(2);
    chk("R8 no pulse on short read", 64'(n_done - d0), 64'h0);
    write_frame(8'h8E, mk(41'h1_2345_6789A, 2'b00, 10'h3FE, 2'b01), 64);
    key_data = 30'h1555_0F0F;
    read_frame("R6 sleep ack 0", {1'b1, 1'b0, 30'h1555_0F0F}, 31, 1);
  endtask

  task automatic t_blank;
    int d0;
    blank_ni = 1'b0; key_req = 1'b1; wait_clk(4);
    chk("R9 blank releases sdo", 64'(sdo), 64'h1);
    write_frame(8'h8E, mk(41'h0_0F0F_F0F0, 2'b01, 10'h00A, 2'b01), 64);
    chk("R9 write accepted while blanked", 64'(seg_g1), 64'h0_0F0F_F0F0);
    d0 = n_done;
    read_frame("R9 read blanked all ones", 32'hFFFF_FFFF, 31, 1);
    wait_clk(2);
    chk("R9 no done while blanked", 64'(n_done - d0), 64'h0);
    blank_ni = 1'b1; key_req = 1'b0; wait_clk(4);
  endtask

  task automatic t_reset_mid;
    rst_ni = 1'b0; wait_clk(2);
    chk("R10 reset clears latches", 64'({sleep, dimmer, seg_g1[0]}), 64'h0);
    chk("R10 reset clears digit2", 64'(seg_g2), 64'h0);
    rst_ni = 1'b1; wait_clk(2);
  endtask

  bit finished = 0;

  initial begin
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(5);
    t_reset();
    t_idle_req();
    t_write_halves();
    t_discard();
    t_read();
    t_blank();
    t_reset_mid();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule